// File: doc/BRIEF.md
# Multicycle 32-bit Processor Core

This core runs a small 32-bit instruction subset one step per clock cycle. Each cycle uses at most one major unit: the single ALU, the single memory port or the register file. Intermediate values are held in internal registers between steps. There is an instruction register, a memory data register, two operand registers and an ALU result register. Instructions that need less work finish sooner, so an instruction takes two to five cycles depending on its kind.

Instructions and data share one memory port. The port has an address, write data, read data and a read strobe and a write strobe. Read data must be valid in the same cycle that the address and read strobe are presented. A write is taken at the clock edge that ends a cycle in which the write strobe is high. Reset is synchronous and active high.

Top module: `mc_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the core presents a fetch: `mem_rd`=1, `mem_wr`=0, `mem_addr`=0 (the program counter resets to 0).
- R2: Every instruction is fetched with `mem_rd`=1 from the program counter. Without a control transfer, the next fetch comes from that address plus 4. The instruction register changes only in a fetch cycle.
- R3: A load (opcode bits [31:26]=0x23) reads the word at reg[bits 25:21] + sign-extended bits [15:0]. It writes that word to reg[bits 20:16] and occupies 5 cycles.
- R4: A store (opcode 0x2B) writes reg[bits 20:16] to address reg[bits 25:21] + sign-extended bits [15:0]. The write strobe is high for exactly one cycle, and that cycle is followed by the next fetch. The store occupies 4 cycles.
- R5: A register operation (opcode 0x00) selects its function from bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. It writes reg[bits 15:11] and occupies 4 cycles.
- R6: Branch-if-equal (opcode 0x04) compares reg[bits 25:21] with reg[bits 20:16]. When they are equal, the next fetch is at address+4 + (sign-extended bits [15:0] shifted left by 2). Otherwise the next fetch is at address+4. The branch occupies 3 cycles.
- R7: A jump (opcode 0x02) fetches next from {bits 31:28 of address+4, bits [25:0], 2'b00} and occupies 3 cycles.
- R8: Register 0 always reads as zero. A load or a register operation that targets register 0 has no effect.
- R9: Any other opcode occupies 2 cycles, writes no memory and no register, and is followed by the fetch at address+4.
- R10: The read strobe and the write strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | XLEN | Byte address of the current memory access |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe (instruction fetch or load) |
| mem_wr | output | 1 | Write strobe for a store |

## Verification
The only visible results are the fetch addresses and the memory writes. The bench logs every fetch on the falling edge, with its cycle number counted from the release of reset. The gap between two consecutive fetches must equal the cycle count of the earlier instruction: 5, 4, 4, 3, 3 or 2. The fetch after a branch or jump must show the computed target. Register contents are brought out by storing them, and each store lands at the edge that ends the store's fourth cycle. Memory is compared only after the program has reached its self-loop, well past every due edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_JUMP = 6'h02;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_LOAD = 6'h23;
   localparam logic [5:0] OPC_STOR = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [3:0] {
      ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB,
      ST_STMEM, ST_EXEC, ST_RWB, ST_BEQ, ST_JMP
   } mc_state_e;

   typedef enum logic {ASRC_PC = 1'b0, ASRC_REG = 1'b1} asrc_e;
   typedef enum logic [1:0] {BSRC_REG, BSRC_FOUR, BSRC_IMM, BSRC_BOFF} bsrc_e;
   typedef enum logic [1:0] {AMODE_ADD, AMODE_SUB, AMODE_FUNCT} alu_mode_e;
   typedef enum logic [1:0] {PCN_HOLD, PCN_INC, PCN_BRANCH, PCN_JUMP} pc_next_e;

   typedef struct packed {
      logic      ir_we;
      pc_next_e  pc_next;
      asrc_e     a_src;
      bsrc_e     b_src;
      alu_mode_e alu_mode;
      logic      rf_we;
      logic      rf_from_mem;
      logic      addr_from_alu;
      logic      mem_rd;
      logic      mem_wr;
   } ctl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  alu_mode_e       mode,
   input  logic [5:0]      funct,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   logic [XLEN-1:0] sum, diff, lt;

   assign sum  = a + b;
   assign diff = a - b;
   assign lt   = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};

   always_comb begin
      unique case (mode)
         AMODE_SUB:   y = diff;
         AMODE_FUNCT: begin
            case (funct)
               FN_SUB:  y = diff;
               FN_AND:  y = a & b;
               FN_OR:   y = a | b;
               FN_SLT:  y = lt;
               default: y = sum;
            endcase
         end
         default:     y = sum;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int XLEN     = 32,
   parameter int NREG     = 32,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NREG)
) (
   input  logic            clk,
   input  logic [AW-1:0]   raddr1,
   input  logic [AW-1:0]   raddr2,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata1,
   output logic [XLEN-1:0] rdata2
);

   if (NREG < 2 || NREG > 32 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("mc_regfile: NREG must be a power of two from 2 to 32");
   end

   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (we) regs[waddr] <= wdata;
   end

   if (ZERO_REG) begin : g_zero
      assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
      assign rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];
   end else begin : g_plain
      assign rdata1 = regs[raddr1];
      assign rdata2 = regs[raddr2];
   end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode,
   output mc_state_e  state_q,
   output ctl_t       ctl
);

   mc_state_e state_d;

   always_comb begin
      state_d = ST_FETCH;
      case (state_q)
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OPC_LOAD, OPC_STOR: state_d = ST_ADDR;
               OPC_REG:            state_d = ST_EXEC;
               OPC_BEQ:            state_d = ST_BEQ;
               OPC_JUMP:           state_d = ST_JMP;
               default:            state_d = ST_FETCH;
            endcase
         end
         ST_ADDR:   state_d = (opcode == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
         ST_LDMEM:  state_d = ST_LDWB;
         ST_EXEC:   state_d = ST_RWB;
         default:   state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   always_comb begin
      ctl = '0;
      case (state_q)
         ST_FETCH: begin
            ctl.mem_rd  = 1'b1;
            ctl.ir_we   = 1'b1;
            ctl.b_src   = BSRC_FOUR;
            ctl.pc_next = PCN_INC;
         end
         ST_DECODE: ctl.b_src = BSRC_BOFF;
         ST_ADDR: begin
            ctl.a_src = ASRC_REG;
            ctl.b_src = BSRC_IMM;
         end
         ST_LDMEM: begin
            ctl.mem_rd        = 1'b1;
            ctl.addr_from_alu = 1'b1;
         end
         ST_LDWB: begin
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mem = 1'b1;
         end
         ST_STMEM: begin
            ctl.mem_wr        = 1'b1;
            ctl.addr_from_alu = 1'b1;
         end
         ST_EXEC: begin
            ctl.a_src    = ASRC_REG;
            ctl.b_src    = BSRC_REG;
            ctl.alu_mode = AMODE_FUNCT;
         end
         ST_RWB: ctl.rf_we = 1'b1;
         ST_BEQ: begin
            ctl.a_src    = ASRC_REG;
            ctl.b_src    = BSRC_REG;
            ctl.alu_mode = AMODE_SUB;
            ctl.pc_next  = PCN_BRANCH;
         end
         ST_JMP: ctl.pc_next = PCN_JUMP;
         default: ;
      endcase
   end

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int               XLEN     = 32,
   parameter int               NREG     = 32,
   parameter logic [XLEN-1:0]  RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_rd,
   output logic            mem_wr
);

   localparam int RIDX  = $clog2(NREG);
   localparam int IMM_W = 16;
   localparam int JT_W  = 26;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_core: the instruction encoding fixes XLEN at 32");
   end

   mc_state_e       state_q;
   ctl_t            ctl;
   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
   logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wdata;
   logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, rf_waddr;
   logic [XLEN-1:0] imm_sx, imm_boff, jump_tgt;
   logic [XLEN-1:0] alu_a, alu_b, alu_y;
   logic            alu_zero;

   assign rs_idx   = ir_q[21 +: RIDX];
   assign rt_idx   = ir_q[16 +: RIDX];
   assign rd_idx   = ir_q[11 +: RIDX];
   assign imm_sx   = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign imm_boff = {imm_sx[XLEN-3:0], 2'b00};
   assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[JT_W-1:0], 2'b00};

   mc_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .opcode  (ir_q[31:26]),
      .state_q (state_q),
      .ctl     (ctl)
   );

   assign rf_waddr = ctl.rf_from_mem ? rt_idx : rd_idx;
   assign rf_wdata = ctl.rf_from_mem ? mdr_q  : alu_out_q;

   mc_regfile #(.XLEN(XLEN), .NREG(NREG), .ZERO_REG(1'b1)) u_rf (
      .clk    (clk),
      .raddr1 (rs_idx),
      .raddr2 (rt_idx),
      .we     (ctl.rf_we),
      .waddr  (rf_waddr),
      .wdata  (rf_wdata),
      .rdata1 (rf_rd1),
      .rdata2 (rf_rd2)
   );

   assign alu_a = (ctl.a_src == ASRC_REG) ? a_q : pc_q;

   always_comb begin
      unique case (ctl.b_src)
         BSRC_FOUR: alu_b = XLEN'(4);
         BSRC_IMM:  alu_b = imm_sx;
         BSRC_BOFF: alu_b = imm_boff;
         default:   alu_b = b_q;
      endcase
   end

   mc_alu #(.XLEN(XLEN)) u_alu (
      .mode  (ctl.alu_mode),
      .funct (ir_q[5:0]),
      .a     (alu_a),
      .b     (alu_b),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RESET_PC;
         ir_q <= '0;
      end else begin
         if (ctl.ir_we) ir_q <= mem_rdata;
         case (ctl.pc_next)
            PCN_INC:    pc_q <= alu_y;
            PCN_BRANCH: if (alu_zero) pc_q <= alu_out_q;
            PCN_JUMP:   pc_q <= jump_tgt;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      mdr_q     <= mem_rdata;
      a_q       <= rf_rd1;
      b_q       <= rf_rd2;
      alu_out_q <= alu_y;
   end

   assign mem_addr  = ctl.addr_from_alu ? alu_out_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
   import mc_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input logic            clk,
   input logic            rst,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic [XLEN-1:0] mem_addr,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] a_q,
   input logic [XLEN-1:0] ir_q,
   input mc_state_e       state_q
);

   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R1
   reset_fetch_chk: assert property (@(posedge clk)
      rst |=> (mem_rd && !mem_wr && mem_addr == RESET_PC));

   // R4
   store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> (!mem_wr && mem_rd && state_q == ST_FETCH));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FETCH) |=> (state_q == ST_DECODE && pc_q == $past(pc_q) + XLEN'(4)));

   // R2
   ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_FETCH) |=> $stable(ir_q));

   // R8
   zero_read_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DECODE && ir_q[25:21] == 5'd0) |=> (a_q == '0));

   // R6
   beq_len_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_BEQ) |=> (state_q == ST_FETCH));

endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .pc_q     (pc_q),
   .a_q      (a_q),
   .ir_q     (ir_q),
   .state_q  (state_q)
);

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;

   localparam int CLK_P  = 10;
   localparam int MWORDS = 256;
   localparam int WD_CYC = 20000;

   localparam logic [5:0] O_LD = 6'h23, O_ST = 6'h2B, O_BQ = 6'h04, O_JP = 6'h02;
   localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25, F_SLT = 6'h2A;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_P/2) clk = ~clk;

   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr;
   logic [31:0] mem [MWORDS];

   assign mem_rdata = mem[mem_addr[9:2]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

   mc_core dut_i (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

   int          cyc, ntr, nwr, nboth;
   logic [31:0] tr_addr [64];
   int          tr_cyc  [64];
   int          n_chk = 0, n_bad = 0;
   bit          done  = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         cyc = 0; ntr = 0; nwr = 0; nboth = 0;
      end else begin
         if (mem_rd && mem_addr < 32'h200 && ntr < 64) begin
            tr_addr[ntr] = mem_addr;
            tr_cyc[ntr]  = cyc;
            ntr++;
         end
         if (mem_wr) nwr++;
         if (mem_wr && mem_rd) nboth++;
         cyc++;
      end
   end

   function automatic logic [31:0] ld(logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
      return {O_LD, rs, rt, imm};
   endfunction
   function automatic logic [31:0] st(logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
      return {O_ST, rs, rt, imm};
   endfunction
   function automatic logic [31:0] rr(logic [4:0] rd, logic [4:0] rs, logic [4:0] rt, logic [5:0] fn);
      return {6'h00, rs, rt, rd, 5'h00, fn};
   endfunction
   function automatic logic [31:0] bq(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {O_BQ, rs, rt, imm};
   endfunction
   function automatic logic [31:0] jp(logic [31:0] addr);
      return {O_JP, addr[27:2]};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_fetch(string req, int idx, logic [31:0] exp_addr, int exp_gap);
      if (idx >= ntr) begin
         n_chk++; n_bad++;
         $display("FAIL %s fetch %0d missing: actual %0d fetches expected more than %0d", req, idx, ntr, idx);
      end else begin
         chk(req, $sformatf("fetch %0d address", idx), tr_addr[idx], exp_addr);
         chk(req, $sformatf("cycles before fetch %0d", idx), 32'(tr_cyc[idx] - tr_cyc[idx-1]), 32'(exp_gap));
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < MWORDS; i++) mem[i] = 32'h0;
   endtask

   task automatic run(int ncyc);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      repeat (ncyc) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      clear_mem();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", "address in reset", mem_addr, 32'h0);
      chk("R1", "read strobe in reset", 32'(mem_rd), 32'h1);
      chk("R1", "write strobe in reset", 32'(mem_wr), 32'h0);
   endtask

   task automatic t_regops();
      clear_mem();
      mem[0] = ld(1, 0, 16'h200);
      mem[1] = ld(2, 0, 16'h204);
      mem[2] = rr(3, 1, 2, F_ADD);
      mem[3] = rr(4, 1, 2, F_SUB);
      mem[4] = rr(5, 1, 2, F_AND);
      mem[5] = rr(6, 1, 2, F_OR);
      mem[6] = rr(7, 1, 2, F_SLT);
      mem[7] = rr(8, 2, 1, F_SLT);
      for (int k = 0; k < 6; k++) mem[8+k] = st(5'(k+3), 0, 16'(16'h300 + 4*k));
      mem[14] = jp(32'h38);
      mem[128] = 32'h0000_00F7;
      mem[129] = 32'hFFFF_FFF0;
      run(75);
      chk("R5", "add", mem[192], 32'h0000_00E7);
      chk("R5", "subtract", mem[193], 32'h0000_0107);
      chk("R5", "and", mem[194], 32'h0000_00F0);
      chk("R5", "or", mem[195], 32'hFFFF_FFF7);
      chk("R5", "slt false", mem[196], 32'h0);
      chk("R5", "slt signed true", mem[197], 32'h1);
      chk("R4", "write cycles for six stores", 32'(nwr), 32'd6);
      chk("R10", "cycles with both strobes", 32'(nboth), 32'd0);
      chk("R2", "first fetch address", tr_addr[0], 32'h0);
      for (int i = 1; i < 16; i++) begin
         chk_fetch((i <= 2) ? "R3" : (i <= 8) ? "R5" : (i <= 14) ? "R4" : "R7",
                   i, (i < 15) ? 32'(4*i) : 32'h38, (i <= 2) ? 5 : (i <= 14) ? 4 : 3);
      end
   endtask

   task automatic t_zero_and_unknown();
      clear_mem();
      mem[0] = ld(0, 0, 16'h200);
      mem[1] = 32'hFC00_0000;
      mem[2] = ld(1, 0, 16'h200);
      mem[3] = rr(0, 1, 1, F_ADD);
      mem[4] = st(0, 0, 16'h300);
      mem[5] = rr(2, 0, 1, F_ADD);
      mem[6] = st(2, 0, 16'h304);
      mem[7] = jp(32'h1C);
      mem[128] = 32'h1234_5678;
      mem[192] = 32'hDEAD_BEEF;
      run(40);
      chk("R8", "stored register 0", mem[192], 32'h0);
      chk("R8", "register 0 as operand", mem[193], 32'h1234_5678);
      chk("R9", "writes (two stores only)", 32'(nwr), 32'd2);
      chk_fetch("R3", 1, 32'h4, 5);
      chk_fetch("R9", 2, 32'h8, 2);
   endtask

   task automatic t_branch();
      logic [31:0] ea [8] = '{32'h4, 32'h8, 32'hC, 32'h10, 32'h18, 32'h1C, 32'h24, 32'h24};
      int          eg [8] = '{5, 5, 5, 3, 3, 4, 3, 3};
      clear_mem();
      mem[0] = ld(1, 0, 16'h200);
      mem[1] = ld(2, 0, 16'h204);
      mem[2] = ld(3, 0, 16'h208);
      mem[3] = bq(1, 3, 16'h0001);
      mem[4] = bq(1, 2, 16'h0001);
      mem[5] = st(1, 0, 16'h300);
      mem[6] = st(3, 0, 16'h304);
      mem[7] = bq(0, 0, 16'h0001);
      mem[8] = st(1, 0, 16'h308);
      mem[9] = bq(0, 0, 16'hFFFF);
      mem[128] = 32'd5; mem[129] = 32'd5; mem[130] = 32'd6;
      mem[192] = 32'hAAAA; mem[194] = 32'hBBBB;
      run(45);
      chk("R6", "skipped store (taken)", mem[192], 32'hAAAA);
      chk("R6", "store after taken branch", mem[193], 32'd6);
      chk("R6", "skipped store (r0 compare)", mem[194], 32'hBBBB);
      for (int i = 1; i <= 8; i++) chk_fetch("R6", i, ea[i-1], eg[i-1]);
   endtask

   task automatic t_jump();
      logic [31:0] ea [6] = '{32'h4, 32'h8, 32'h40, 32'h44, 32'h48, 32'h48};
      int          eg [6] = '{5, 5, 3, 4, 4, 3};
      clear_mem();
      mem[0]  = ld(1, 0, 16'h200);
      mem[1]  = ld(2, 1, 16'hFFFC);
      mem[2]  = jp(32'h40);
      mem[3]  = st(2, 0, 16'h300);
      mem[16] = st(2, 0, 16'h304);
      mem[17] = st(1, 1, 16'hFFF8);
      mem[18] = jp(32'h48);
      mem[128] = 32'h0000_020C;
      mem[130] = 32'h0000_0055;
      mem[192] = 32'h1111_1111;
      run(35);
      chk("R7", "store skipped by jump", mem[192], 32'h1111_1111);
      chk("R3", "load with negative offset", mem[193], 32'h55);
      chk("R4", "store with negative offset", mem[129], 32'h0000_020C);
      for (int i = 1; i <= 6; i++) chk_fetch("R7", i, ea[i-1], eg[i-1]);
   endtask

   task automatic t_reset_mid();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "address after mid-run reset", mem_addr, 32'h0);
      chk("R1", "read strobe after mid-run reset", 32'(mem_rd), 32'h1);
      chk("R1", "write strobe after mid-run reset", 32'(mem_wr), 32'h0);
   endtask

   initial begin
      t_reset();
      t_regops();
      t_zero_and_unknown();
      t_branch();
      t_jump();
      t_reset_mid();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", WD_CYC);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule